// File: doc/BRIEF.md
# Key-Protected Independent Watchdog

This block is a free-running safety timer that pulls a system reset request when software stops servicing it. A 12-bit down-counter advances on a divided copy of a slow tick enable, `tick_en`, which comes from a low-speed oscillator domain and is independent of the bus. Software talks to it through four word registers. Writing magic values to the key register opens the configuration registers, starts the timer or refreshes the count. Once running, the timer cannot be halted by any write.

The prescaler and reload registers are write-protected. The only way to unlock them is an unlock key, and the refresh and start keys lock them again. An accepted configuration write is not used by the counter at once. It becomes active a fixed number of slow ticks later, and a status bit is set for each register while its update is still in flight. A strap input can also start the timer straight out of reset.

Top module: `kwdt_top`

## Requirements
- R1: After reset the timer is stopped (unless strapped), `rst_req` is low, the prescaler reads 0, the reload reads 0xFFF, the status reads 0 and the key register reads 0.
- R2: Writing 0xCCCC to the key register (address 0) starts the timer with the count at 0xFFF; with prescaler code 0 the first reset request follows 4096×4 ticks after the start write.
- R3: A running timer never stops: writes of any other value to the key register leave the pending timeout unchanged.
- R4: Writing 0xAAAA to the key register while running loads the count from the active reload value R and restarts the prescaler; the reset request follows (R+1)×D ticks later, where D is the divide ratio.
- R5: `rst_req` is a one-clock pulse raised when a prescaled step finds the count at zero; the count then reloads from the active reload value and keeps running, so the next request follows another (R+1)×D ticks.
- R6: The prescaler register (address 1, bits 2:0) selects D = 4·2^code for codes 0 to 6; code 7 also gives D = 256.
- R7: The prescaler and reload (address 2, bits 11:0) registers ignore writes until 0x5555 is written to the key register.
- R8: Writing 0xAAAA or 0xCCCC to the key register withdraws write access; any other non-unlock value leaves the access state as it was.
- R9: The status register (address 3) shows bit 0 while a prescaler update is pending and bit 1 while a reload update is pending; each bit sets on an accepted write and clears after SYNC_TICKS ticks (3 by default).
- R10: The counter and prescaler keep using the previous value until the matching pending bit clears; a refresh during that window loads the old reload value.
- R11: With `autostart` high during reset the timer runs from reset with no start key; with it low, refresh keys before a start produce no reset request.
- R12: Register reads are combinational from `bus_addr`; unused read bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Low-speed tick, one clock wide per tick |
| autostart | input | 1 | Strap: run from reset when high |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 key, 1 prescaler, 2 reload, 3 status |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| rst_req | output | 1 | One-clock reset request pulse |

## Verification
The bench builds the block with its default parameters: a 12-bit counter, a 3-bit prescaler code and a three-tick update delay. At those values the full 0xFFF start timeout at divide-by-4 is only about sixteen thousand ticks, so the start, strap and no-stop paths are measured end to end, along with the divide-by-256 saturation of code 7. The short update delay lets the bench place a refresh inside the pending window and show that the old reload value is still in use.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_UNLOCK  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_REFRESH = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_START   = 16'hCCCC;

  typedef enum logic [1:0] {
    REG_KEY  = 2'd0,
    REG_PRE  = 2'd1,
    REG_RLD  = 2'd2,
    REG_STAT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/kwdt_keyctl.sv
module kwdt_keyctl
  import kwdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             autostart,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key_val,
  output logic             unlocked,
  output logic             running,
  output logic             start_pulse,
  output logic             refresh_pulse
);
  logic unlocked_d, running_d;
  logic is_unlock, is_refresh, is_start;

  always_comb begin
    is_unlock     = key_wr && (key_val == KEY_UNLOCK);
    is_refresh    = key_wr && (key_val == KEY_REFRESH);
    is_start      = key_wr && (key_val == KEY_START);
    start_pulse   = is_start && !running;
    refresh_pulse = is_refresh && running;
    unlocked_d    = unlocked;
    if (is_refresh || is_start) unlocked_d = 1'b0;
    else if (is_unlock)         unlocked_d = 1'b1;
    running_d     = running || is_start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      running  <= autostart;
    end else begin
      unlocked <= unlocked_d;
      running  <= running_d;
    end
  end
endmodule

// File: rtl/kwdt_cfgreg.sv
module kwdt_cfgreg #(
  parameter int         W          = 12,
  parameter logic [W-1:0] RST_VAL  = '0,
  parameter int         SYNC_TICKS = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         pending
);
  localparam int PW = $clog2(SYNC_TICKS + 1);
  localparam logic [PW-1:0] PLOAD = PW'(SYNC_TICKS);

  logic [PW-1:0] pcnt, pcnt_d;
  logic [W-1:0]  shadow_d, active_d;

  always_comb begin
    shadow_d = shadow;
    active_d = active;
    pcnt_d   = pcnt;
    if (wr_en) begin
      shadow_d = wdata;
      pcnt_d   = PLOAD;
    end else if (tick_en && (pcnt != '0)) begin
      pcnt_d = pcnt - 1'b1;
      if (pcnt == PW'(1)) active_d = shadow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= RST_VAL;
      active <= RST_VAL;
      pcnt   <= '0;
    end else begin
      shadow <= shadow_d;
      active <= active_d;
      pcnt   <= pcnt_d;
    end
  end

  assign pending = (pcnt != '0);
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
  parameter int PRE_W     = 3,
  parameter int MIN_SHIFT = 2,
  parameter int MAX_CODE  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             run,
  input  logic             clear,
  input  logic [PRE_W-1:0] code,
  output logic             step
);
  localparam int PDIV_W = MIN_SHIFT + MAX_CODE;

  logic [PDIV_W-1:0] pdiv, pdiv_d, last;
  logic [PRE_W-1:0]  code_sat;

  always_comb begin
    code_sat = (code > PRE_W'(MAX_CODE)) ? PRE_W'(MAX_CODE) : code;
    last     = (PDIV_W'(1) << (int'(code_sat) + MIN_SHIFT)) - 1'b1;
    step     = run && tick_en && !clear && (pdiv >= last);
    pdiv_d   = pdiv;
    if (clear)                pdiv_d = '0;
    else if (step)            pdiv_d = '0;
    else if (run && tick_en)  pdiv_d = pdiv + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pdiv <= '0;
    else        pdiv <= pdiv_d;
  end
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_full,
  input  logic             refresh,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             step,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt, cnt_d;
  logic             rst_req_d;

  always_comb begin
    cnt_d     = cnt;
    rst_req_d = 1'b0;
    if (load_full) begin
      cnt_d = '1;
    end else if (refresh) begin
      cnt_d = reload_val;
    end else if (step) begin
      if (cnt == '0) begin
        rst_req_d = 1'b1;
        cnt_d     = reload_val;
      end else begin
        cnt_d = cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '1;
      rst_req <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      rst_req <= rst_req_d;
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int PRE_W      = 3,
  parameter int DATA_W     = 16,
  parameter int SYNC_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              autostart,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  logic             unlocked, running, start_pulse, refresh_pulse, step;
  logic             key_wr, pre_wr, rld_wr;
  logic [PRE_W-1:0] pre_shadow, pre_active;
  logic [CNT_W-1:0] rld_shadow, rld_active;
  logic             pre_pending, rld_pending;
  reg_sel_e         sel;

  always_comb begin
    sel    = reg_sel_e'(bus_addr);
    key_wr = bus_wr && (sel == REG_KEY);
    pre_wr = bus_wr && (sel == REG_PRE) && unlocked;
    rld_wr = bus_wr && (sel == REG_RLD) && unlocked;
  end

  kwdt_keyctl u_key (
    .clk(clk), .rst_n(rst_n), .autostart(autostart),
    .key_wr(key_wr), .key_val(bus_wdata[KEY_W-1:0]),
    .unlocked(unlocked), .running(running),
    .start_pulse(start_pulse), .refresh_pulse(refresh_pulse)
  );

  kwdt_cfgreg #(.W(PRE_W), .RST_VAL('0), .SYNC_TICKS(SYNC_TICKS)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(pre_wr),
    .wdata(bus_wdata[PRE_W-1:0]), .shadow(pre_shadow),
    .active(pre_active), .pending(pre_pending)
  );

  kwdt_cfgreg #(.W(CNT_W), .RST_VAL('1), .SYNC_TICKS(SYNC_TICKS)) u_rld (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(rld_wr),
    .wdata(bus_wdata[CNT_W-1:0]), .shadow(rld_shadow),
    .active(rld_active), .pending(rld_pending)
  );

  kwdt_prescale #(.PRE_W(PRE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .run(running),
    .clear(start_pulse || refresh_pulse), .code(pre_active), .step(step)
  );

  kwdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_full(start_pulse),
    .refresh(refresh_pulse), .reload_val(rld_active),
    .step(step), .rst_req(rst_req)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      REG_PRE:  bus_rdata[PRE_W-1:0] = pre_shadow;
      REG_RLD:  bus_rdata[CNT_W-1:0] = rld_shadow;
      REG_STAT: bus_rdata[1:0]       = {rld_pending, pre_pending};
      default:  bus_rdata            = '0;
    endcase
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int CNT_W  = 12,
  parameter int PRE_W  = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rst_req,
  input logic              running,
  input logic              unlocked,
  input logic [PRE_W-1:0]  pre_shadow,
  input logic [PRE_W-1:0]  pre_active,
  input logic              pre_pending,
  input logic [CNT_W-1:0]  rld_shadow,
  input logic [CNT_W-1:0]  rld_active,
  input logic              rld_pending
);
  // R3
  running_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);

  // R5
  rst_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> running);

  // R7
  locked_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd1 && !unlocked) |=> $stable(pre_shadow));

  // R7
  locked_rld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && !unlocked) |=> $stable(rld_shadow));

  // R8
  refresh_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && bus_wdata == 16'hAAAA) |=> !unlocked);

  // R9
  rld_pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd2 && unlocked) |=> rld_pending);

  // R10
  pre_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pre_pending) |-> (pre_active == pre_shadow));

  // R10
  rld_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rld_pending) |-> (rld_active == rld_shadow));
endmodule

bind kwdt_top kwdt_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rst_req(rst_req), .running(running),
  .unlocked(unlocked), .pre_shadow(pre_shadow), .pre_active(pre_active),
  .pre_pending(pre_pending), .rld_shadow(rld_shadow),
  .rld_active(rld_active), .rld_pending(rld_pending)
);

// File: tb/kwdt_top_bench.sv
`timescale 1ns/1ps
module kwdt_top_bench;
  logic        clk, rst_n, tick_en, autostart, bus_wr;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        rst_req;
  int checks, failures;
  bit done;

  kwdt_top u_kwdt_top (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .autostart(autostart),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 1'b0; autostart = strap; tick_en = 1'b0;
    bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a; #1; v = int'(bus_rdata);
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk); tick_en = 1'b0;
  endtask

  // count ticks from now until rst_req, then confirm it is one clock wide
  task automatic measure(input string tag, input int exp);
    int n = 0;
    tick_en = 1'b1;
    while (n < exp + 64) begin
      @(posedge clk); @(negedge clk); n++;
      if (rst_req) break;
    end
    tick_en = 1'b0;
    check(tag, n, exp);
    @(posedge clk); @(negedge clk);
    check({tag, " R5 pulse"}, int'(rst_req), 0);
  endtask

  task automatic cfg_and_run(input int code, input int rl);
    do_reset(1'b0);
    wr(2'd0, 16'h5555);
    wr(2'd1, 16'(code));
    wr(2'd2, 16'(rl));
    ticks(3);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'hAAAA);
  endtask

  task automatic t_reset();
    int v;
    do_reset(1'b0);
    check("R1 rst_req", int'(rst_req), 0);
    rd(2'd1, v); check("R1 prescaler", v, 0);
    rd(2'd2, v); check("R1 reload", v, 4095);
    rd(2'd3, v); check("R1 status", v, 0);
    rd(2'd0, v); check("R12 key reads zero", v, 0);
  endtask

  task automatic t_lock();
    int v;
    do_reset(1'b0);
    wr(2'd1, 16'd5); wr(2'd2, 16'd7);
    rd(2'd1, v); check("R7 locked prescaler", v, 0);
    rd(2'd2, v); check("R7 locked reload", v, 4095);
    wr(2'd0, 16'h5555); wr(2'd0, 16'h1234);
    wr(2'd1, 16'd5);
    rd(2'd1, v); check("R8 other key keeps access", v, 5);
    wr(2'd0, 16'hAAAA); wr(2'd1, 16'd2);
    rd(2'd1, v); check("R8 refresh key relocks", v, 5);
    wr(2'd0, 16'h5555); wr(2'd0, 16'hCCCC); wr(2'd2, 16'd9);
    rd(2'd2, v); check("R8 start key relocks", v, 4095);
  endtask

  task automatic t_status();
    int v;
    do_reset(1'b0);
    wr(2'd0, 16'h5555); wr(2'd1, 16'd3);
    rd(2'd3, v); check("R9 prescaler pending set", v, 1);
    ticks(2);
    rd(2'd3, v); check("R9 still pending", v, 1);
    ticks(1);
    rd(2'd3, v); check("R9 prescaler pending clear", v, 0);
    wr(2'd2, 16'd100);
    rd(2'd3, v); check("R9 reload pending set", v, 2);
    ticks(3);
    rd(2'd3, v); check("R9 reload pending clear", v, 0);
    rd(2'd2, v); check("R12 reload readback", v, 100);
  endtask

  task automatic t_start();
    do_reset(1'b0);
    wr(2'd0, 16'hCCCC);
    measure("R2 start timeout", 4096 * 4);
  endtask

  task automatic t_nostop();
    do_reset(1'b0);
    wr(2'd0, 16'hCCCC);
    wr(2'd0, 16'h0000); wr(2'd0, 16'hFFFF); wr(2'd0, 16'hCCCC);
    measure("R3 cannot stop", 4096 * 4);
  endtask

  task automatic t_periods();
    cfg_and_run(0, 5);
    measure("R4 refresh period", 24);
    measure("R5 reload after expiry", 24);
    cfg_and_run(3, 1);
    measure("R6 code3", 64);
    cfg_and_run(6, 0);
    measure("R6 code6", 256);
    cfg_and_run(7, 0);
    measure("R6 code7 saturates", 256);
  endtask

  task automatic t_deferred();
    cfg_and_run(0, 5);
    wr(2'd0, 16'h5555);
    wr(2'd2, 16'd50);
    wr(2'd0, 16'hAAAA);
    measure("R10 old reload in window", 24);
    wr(2'd0, 16'hAAAA);
    measure("R10 new reload after commit", 204);
  endtask

  task automatic t_strap();
    int n = 0;
    do_reset(1'b1);
    wr(2'd0, 16'h5555); wr(2'd2, 16'd2); ticks(3);
    wr(2'd0, 16'hAAAA);
    measure("R11 strap runs", 12);
    do_reset(1'b0);
    wr(2'd0, 16'h5555); wr(2'd2, 16'd2); ticks(3);
    wr(2'd0, 16'hAAAA);
    tick_en = 1'b1;
    repeat (100) begin
      @(posedge clk); @(negedge clk);
      if (rst_req) n++;
    end
    tick_en = 1'b0;
    check("R11 idle without start", n, 0);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    t_reset();
    t_lock();
    t_status();
    t_start();
    t_nostop();
    t_periods();
    t_deferred();
    t_strap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule